// File: doc/BRIEF.md
# Write-Through Data Cache Controller

This block sits between a pipeline's memory stage and a word-addressed main memory. The pipeline presents a request each cycle: a valid flag, a read/write selector, a 32-bit word address and 32-bit write data. The block returns read data and a stall flag. While the stall flag is high, the pipeline holds its request unchanged.

The cache is direct-mapped, with one word per line. Each line holds a valid bit and a tag taken from the address bits above the index. A read that hits returns data in the same cycle. A read that misses issues one read to main memory and raises the stall flag for a fixed number of cycles. The filled word is then presented on the cycle the stall flag drops, and the line is marked valid at the end of that cycle.

Every write is forwarded to main memory in the same cycle it is accepted. A write hit also refreshes the cached word. A write miss does not allocate a line. Because writes never bypass memory, main memory after any run matches what an uncached design would leave behind.

Top module: `wt_dcache`

## Requirements
- R1: A synchronous reset clears every valid bit, so the first read of any address after reset misses.
- R2: A read miss raises `stall` in the cycle it is detected and keeps it high for exactly MISS_CYC (default 8) consecutive cycles. In the following cycle `stall` is low and `rsp_rdata` equals the word main memory held at that address.
- R3: A read whose line is valid with a matching tag returns the stored word in the same cycle with `stall` low.
- R4: Every accepted write drives `mem_en`=1, `mem_we`=1, `mem_addr`=`req_addr` and `mem_wdata`=`req_wdata` in the same cycle, with `stall` low, whether it hits or misses.
- R5: A write hit updates the cached word, so a later read of that address hits and returns the written value.
- R6: A write miss leaves the cache unchanged (no allocation), so a later read of that address misses.
- R7: The line index is `req_addr[IDX_W-1:0]` (IDX_W = log2(LINES), default 4) and the tag is the remaining upper bits. A fill to an index replaces whatever address held it, so the evicted address misses again on its next read.
- R8: After any request sequence, main memory contents equal those produced by applying the same writes without a cache.
- R9: With no pending request and no miss in service, `mem_en` is low and `stall` is low.
- R10: A miss issues exactly one memory read, in its detection cycle. `mem_en` stays low in the remaining stall cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Memory-stage request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data |
| stall | output | 1 | Freeze the pipeline |
| mem_en | output | 1 | Main memory access enable |
| mem_we | output | 1 | Main memory write enable |
| mem_addr | output | 32 | Main memory word address |
| mem_wdata | output | 32 | Main memory write data |
| mem_rdata | input | 32 | Main memory read data, one cycle after a read |

## Verification
The hardest cases to reach from the ports are those that need a precise cache history. Examples are a write miss to an index whose line holds a different tag, or an eviction followed by a re-read of the evicted address. Random traffic reaches these situations only by luck.

Directed sequences set them up explicitly: fill an index, write-miss a conflicting address, re-read both, then reset while lines are valid and re-read. Seeded random traffic is drawn from a pool of four tags over sixteen indexes, so hits, conflicts and write hits occur densely. The bench keeps its own valid/tag model and reference memory to predict hit or miss and the returned data.

// File: rtl/dcache_pkg.sv
`timescale 1ns/1ps
package dcache_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_FILL = 2'd1,
        FS_DONE = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic  valid;
        logic  write;
        addr_t addr;
        word_t wdata;
    } core_req_t;

    typedef struct packed {
        logic  en;
        logic  we;
        addr_t addr;
        word_t wdata;
    } mem_cmd_t;

    function automatic mem_cmd_t mem_idle();
        mem_cmd_t c;
        c.en    = 1'b0;
        c.we    = 1'b0;
        c.addr  = '0;
        c.wdata = '0;
        return c;
    endfunction

endpackage

// File: rtl/dcache_tag_store.sv
`timescale 1ns/1ps
module dcache_tag_store #(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES),
    parameter int TAG_W = 32 - IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit_o,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (set_en) begin
            valid_q[set_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_q[set_idx] <= set_tag;
        end
    end

    always_comb begin
        hit_o = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
    end

    // R1: the cycle after reset, no line is valid
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0));

endmodule

// File: rtl/dcache_data_store.sv
`timescale 1ns/1ps
module dcache_data_store #(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic                   clk,
    input  logic [IDX_W-1:0]       rd_idx,
    output dcache_pkg::word_t      rd_data,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  dcache_pkg::word_t      wr_data
);

    dcache_pkg::word_t words_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_data = words_q[rd_idx];
    end

endmodule

// File: rtl/dcache_fill_ctrl.sv
`timescale 1ns/1ps
module dcache_fill_ctrl #(
    parameter int MISS_CYC = 8,
    parameter int CNT_W    = $clog2(MISS_CYC)
) (
    input  logic clk,
    input  logic rst,
    input  logic miss_i,
    output logic stall_o,
    output logic issue_o,
    output logic capture_o,
    output logic done_o,
    output logic busy_o
);
    import dcache_pkg::*;

    fill_state_e      st_q;
    logic [CNT_W-1:0] cnt_q;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MISS_CYC - 1);

    initial begin
        a_r2_param_range: assert (MISS_CYC >= 3);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= FS_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                FS_IDLE: begin
                    if (miss_i) begin
                        st_q  <= FS_FILL;
                        cnt_q <= CNT_W'(1);
                    end
                end
                FS_FILL: begin
                    if (cnt_q == CNT_LAST) begin
                        st_q <= FS_DONE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: st_q <= FS_IDLE;
            endcase
        end
    end

    always_comb begin
        issue_o   = (st_q == FS_IDLE) && miss_i;
        stall_o   = issue_o || (st_q == FS_FILL);
        capture_o = (st_q == FS_FILL) && (cnt_q == CNT_W'(1));
        done_o    = (st_q == FS_DONE);
        busy_o    = (st_q != FS_IDLE);
    end

    // R2: the word is presented only right after the fill window, with stall low
    a_r2_done_follows_fill: assert property (@(posedge clk) disable iff (rst)
        (st_q == FS_DONE) |-> ($past(st_q) == FS_FILL && !stall_o));

    // R2: a detected miss always enters the fill window
    a_r2_miss_enters_fill: assert property (@(posedge clk) disable iff (rst)
        issue_o |=> (st_q == FS_FILL && stall_o));

endmodule

// File: rtl/wt_dcache.sv
`timescale 1ns/1ps
module wt_dcache #(
    parameter int LINES    = 16,
    parameter int MISS_CYC = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic [31:0] rsp_rdata,
    output logic        stall,
    output logic        mem_en,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);
    import dcache_pkg::*;

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    core_req_t        req;
    mem_cmd_t         cmd;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             hit;
    logic             rd_miss;
    logic             wr_hit;
    logic             f_stall, f_issue, f_capture, f_done, f_busy;
    word_t            line_word;
    word_t            fill_q;
    logic             dwr_en;
    word_t            dwr_data;

    always_comb begin
        req.valid = req_valid;
        req.write = req_write;
        req.addr  = req_addr;
        req.wdata = req_wdata;
        idx       = req.addr[IDX_W-1:0];
        tag       = req.addr[ADDR_W-1:IDX_W];
    end

    dcache_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .look_idx (idx),
        .look_tag (tag),
        .hit_o    (hit),
        .set_en   (f_done),
        .set_idx  (idx),
        .set_tag  (tag)
    );

    dcache_data_store #(.LINES(LINES), .IDX_W(IDX_W)) u_data (
        .clk     (clk),
        .rd_idx  (idx),
        .rd_data (line_word),
        .wr_en   (dwr_en),
        .wr_idx  (idx),
        .wr_data (dwr_data)
    );

    always_comb begin
        rd_miss = !rst && req.valid && !req.write && !hit;
        wr_hit  = !rst && !f_busy && req.valid && req.write && hit;
    end

    dcache_fill_ctrl #(.MISS_CYC(MISS_CYC)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .miss_i    (rd_miss),
        .stall_o   (f_stall),
        .issue_o   (f_issue),
        .capture_o (f_capture),
        .done_o    (f_done),
        .busy_o    (f_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (f_capture) begin
            fill_q <= mem_rdata;
        end
    end

    always_comb begin
        dwr_en   = f_done || wr_hit;
        dwr_data = f_done ? fill_q : req.wdata;
    end

    always_comb begin
        cmd = mem_idle();
        if (!rst && !f_busy && req.valid) begin
            if (req.write) begin
                cmd.en    = 1'b1;
                cmd.we    = 1'b1;
                cmd.addr  = req.addr;
                cmd.wdata = req.wdata;
            end else if (f_issue) begin
                cmd.en   = 1'b1;
                cmd.addr = req.addr;
            end
        end
    end

    always_comb begin
        mem_en    = cmd.en;
        mem_we    = cmd.we;
        mem_addr  = cmd.addr;
        mem_wdata = cmd.wdata;
        stall     = f_stall;
        rsp_rdata = f_done ? fill_q : line_word;
    end

    // R4: an accepted write reaches memory at once and never stalls
    a_r4_write_through: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !f_busy) |-> (mem_en && mem_we && !stall));

    // R3: a read hit never stalls
    a_r3_hit_no_stall: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && hit && !f_busy) |-> !stall);

    // R9: no request and no fill means a quiet memory port
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !f_busy) |-> (!mem_en && !stall));

    // R10: only the detection cycle of a stall touches memory
    a_r10_single_read: assert property (@(posedge clk) disable iff (rst)
        (stall && $past(stall)) |-> !mem_en);

endmodule

// File: tb/wt_dcache_tb_top.sv
`timescale 1ns/1ps
module wt_dcache_tb_top;

    localparam int LINES    = 16;
    localparam int MISS_CYC = 8;
    localparam int MEM_W    = 1024;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [31:0] req_addr, req_wdata;
    logic [31:0] rsp_rdata;
    logic        stall, mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [31:0] mem     [MEM_W];
    logic [31:0] ref_mem [MEM_W];
    logic        ref_valid [LINES];
    logic [27:0] ref_tag   [LINES];

    always #10 clk = ~clk;

    wt_dcache #(.LINES(LINES), .MISS_CYC(MISS_CYC)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .stall(stall),
        .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:0]];
        end
    end

    function automatic logic [31:0] init_word(int i);
        return (i * 32'h9E37_79B9) ^ 32'h5A5A_0000 ^ i;
    endfunction

    task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic clear_ref();
        for (int i = 0; i < LINES; i++) ref_valid[i] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_ref();
        #1;
        chk(!stall && !mem_en, "R9", {30'd0, stall, mem_en}, 32'd0);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(!stall && !mem_en, "R9", {30'd0, stall, mem_en}, 32'd0);
    endtask

    // lbl names the requirement the hit/miss prediction stands for
    task automatic access(bit wr, logic [31:0] a, logic [31:0] d, string lbl);
        logic [3:0]  ix;
        logic [27:0] tg;
        bit          exp_hit;
        int          n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        ix = a[3:0];
        tg = a[31:4];
        exp_hit = ref_valid[ix] && (ref_tag[ix] == tg);
        if (wr) begin
            chk(!stall, "R4", {31'd0, stall}, 32'd0);
            chk(mem_en && mem_we && mem_addr == a && mem_wdata == d, "R4",
                mem_wdata, d);
            ref_mem[a[9:0]] = d;
        end else if (exp_hit) begin
            chk(!stall, lbl, {31'd0, stall}, 32'd0);
            chk(rsp_rdata == ref_mem[a[9:0]], lbl, rsp_rdata, ref_mem[a[9:0]]);
        end else begin
            chk(stall, lbl, {31'd0, stall}, 32'd1);
            chk(mem_en && !mem_we && mem_addr == a, "R10", mem_addr, a);
            n = 0;
            while (stall && n < 20) begin
                n++;
                @(negedge clk);
                #1;
                if (stall) chk(!mem_en, "R10", {31'd0, mem_en}, 32'd0);
            end
            chk(n == MISS_CYC, "R2", n, MISS_CYC);
            chk(rsp_rdata == ref_mem[a[9:0]], "R2", rsp_rdata, ref_mem[a[9:0]]);
            ref_valid[ix] = 1'b1;
            ref_tag[ix]   = tg;
        end
    endtask

    initial begin
        int bad;
        void'($urandom(32'd20250611));
        for (int i = 0; i < MEM_W; i++) begin
            mem[i]     = init_word(i);
            ref_mem[i] = init_word(i);
        end
        clear_ref();
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
        do_reset();

        // directed: miss, hit, write hit, write miss, conflicts
        access(1'b0, 32'd5,  '0, "R1");
        access(1'b0, 32'd5,  '0, "R3");
        access(1'b1, 32'd5,  32'hCAFE_0005, "R4");
        access(1'b0, 32'd5,  '0, "R5");
        access(1'b1, 32'd21, 32'hBEEF_0021, "R4");   // same index, other tag
        access(1'b0, 32'd5,  '0, "R6");              // line still holds addr 5
        access(1'b0, 32'd21, '0, "R6");              // no allocation: miss
        access(1'b0, 32'd5,  '0, "R7");              // evicted by 21: miss
        access(1'b0, 32'd37, '0, "R7");
        access(1'b0, 32'd21, '0, "R7");
        idle_cycle();

        // seeded random traffic
        for (int k = 0; k < 600; k++) begin
            logic [31:0] a;
            a = 32'($urandom_range(0, 63));
            if ($urandom_range(0, 9) == 0) idle_cycle();
            if ($urandom_range(0, 2) == 0)
                access(1'b1, a, $urandom(), "R4");
            else
                access(1'b0, a, '0, "R3");
        end

        // reset with warm lines: every index misses again
        do_reset();
        for (int i = 0; i < LINES; i++) access(1'b0, 32'(i), '0, "R1");
        for (int i = 0; i < LINES; i++) access(1'b0, 32'(i), '0, "R3");
        idle_cycle();
        idle_cycle();

        bad = 0;
        for (int i = 0; i < MEM_W; i++) if (mem[i] !== ref_mem[i]) bad++;
        chk(bad == 0, "R8", bad, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule